// File: doc/BRIEF.md
# Serial-Clock Hold Sequencer for Sync Reset and Power-Down

This block watches a serial clock line whose idle level is low. When the host holds that line high for several whole conversion frames, the block first puts the converter into a synchronization reset. If the line stays high for long enough, it then asks for power-down. The block keeps its own conversion frame timer and reports each frame boundary on `frame_start`. It counts whole frames in which the line never went low. A single low cycle anywhere in a frame restarts that count.

On entry to synchronization, the block takes over the shared data/ready pin. It drives the pin low for exactly one system clock and then holds it high. A falling edge of the serial clock, seen while in either held state, releases the converter. The frame timer restarts at that edge. The data-ready qualifier stays low until the restarted filter has settled over a set number of frames, so the first ready indication after release carries valid data. While power-down is active, frame timing is frozen and only the falling-edge detector keeps running.

Top module: `sclk_hold_sequencer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `mod_reset`, `pwr_down`, `pin_force_en` and `valid_gate` are all 0.
- R2: Once the serial clock has been high for `SYNC_FRAMES` (4) complete frames, `mod_reset` and `pin_force_en` rise one cycle after the boundary that ends the fourth frame. In that first cycle `pin_force_val` is 0, and from the following cycle it is 1 for as long as the override lasts.
- R3: Fewer than 4 complete high frames have no effect on `mod_reset`. A low level in any single cycle of a frame restarts the count, so 4 further whole high frames are then needed.
- R4: After `PD_FRAMES` (20) complete high frames in total, `pwr_down` rises one cycle after the twentieth boundary. `mod_reset` stays 1 throughout power-down.
- R5: A falling edge of the serial clock while `mod_reset` is 1 clears `mod_reset`, `pwr_down` and `pin_force_en` at the next clock edge. If the falling edge arrives in the same cycle that the power-down threshold is reached, the release wins and power-down is never entered.
- R6: `valid_gate` stays 0 until `SETTLE_FRAMES` (5) frame boundaries have passed since reset or since a release. It is 1 from the edge of the fifth boundary onward, as long as no reset state is active.
- R7: On release the frame timer restarts: the first `frame_start` pulse is high in the cycle that follows the 15th clock edge after the release edge (`FRAME_LEN` = 16 in the bench).
- R8: While `pwr_down` is 1, `frame_start` never pulses.
- R9: The frame count saturates at 20. Holding the line high well past 20 frames keeps power-down active, and a later falling edge still releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_lvl | input | 1 | Serial clock level, already synchronized to `clk` |
| frame_start | output | 1 | One-cycle strobe at the last cycle of each conversion frame |
| mod_reset | output | 1 | Holds the modulator and filter in reset |
| pwr_down | output | 1 | Power-down request |
| pin_force_en | output | 1 | Override enable for the shared data/ready pin |
| pin_force_val | output | 1 | Level driven on the pin while the override is enabled |
| valid_gate | output | 1 | High once the filter has settled; qualifies data-ready |

## Verification
Two events can land in the same cycle: the falling edge of the serial clock that releases the held state, and the frame count reaching the power-down threshold. The bench holds the line high until the twentieth boundary has updated the count. It then drops the line so that the next edge sees the fall and the threshold together, and checks that neither `pwr_down` nor `mod_reset` is set afterwards. A second kind of coincidence is a single low cycle inside an otherwise high frame. It is judged by the extra frames that must pass before `mod_reset` rises.

// File: rtl/sclk_hold_pkg.sv
// Package: shared types for the serial-clock hold sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sclk_hold_pkg;

    // Sequencer operating state
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SYNC = 2'd1,
        ST_PDN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sqh_frame_timer.sv
// Module: conversion frame timer.
// Counts FRAME_LEN system clocks per frame and flags the last cycle.
// Assumes: restart has priority over freeze; while frozen the count holds
// and no tick is produced.
module sqh_frame_timer #(
    parameter int FRAME_LEN = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic freeze,
    output logic tick
);
    localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] pos_q;

    // Last cycle of the frame, suppressed while frozen
    always_comb tick = (pos_q == LAST) && !freeze;

    // Position inside the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q <= '0;
        end else if (!freeze) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/sqh_hold_counter.sv
// Module: whole-frame high counter.
// Counts consecutive frames during which the level stayed high in every
// cycle; saturates at SAT_FRAMES, clears on a frame with any low cycle.
// Assumes: tick marks the final cycle of a frame.
module sqh_hold_counter #(
    parameter int SAT_FRAMES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic lvl,
    output logic [$clog2(SAT_FRAMES+1)-1:0] count
);
    localparam int NW = $clog2(SAT_FRAMES + 1);
    localparam logic [NW-1:0] SAT = NW'(SAT_FRAMES);

    logic all_high_q;
    logic frame_ok;

    // Frame counts only if every cycle so far, including this one, was high
    always_comb frame_ok = all_high_q && lvl;

    // High-tracking flag and saturating frame count
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            all_high_q <= 1'b1;
            count      <= '0;
        end else if (tick) begin
            all_high_q <= 1'b1;
            if (!frame_ok)
                count <= '0;
            else if (count != SAT)
                count <= count + 1'b1;
        end else begin
            all_high_q <= frame_ok;
        end
    end
endmodule

// File: rtl/sqh_fall_detect.sv
// Module: falling-edge detector on an already synchronized level.
// Assumes: the level idles low, so the history register resets to 0.
module sqh_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_q;

    // One cycle of level history
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // High-to-low transition seen this cycle
    always_comb fall = lvl_q && !lvl;
endmodule

// File: rtl/sclk_hold_sequencer.sv
// Module: serial-clock hold sequencer (top).
// Enters sync reset after SYNC_FRAMES whole high frames and power-down
// after PD_FRAMES; a falling serial clock edge releases both and restarts
// frame timing. Qualifies data-ready until SETTLE_FRAMES frames have passed.
// Assumes: sclk_lvl is synchronous to clk; PD_FRAMES > SYNC_FRAMES.
module sclk_hold_sequencer
    import sclk_hold_pkg::*;
#(
    parameter int FRAME_LEN     = 384,
    parameter int SYNC_FRAMES   = 4,
    parameter int PD_FRAMES     = 20,
    parameter int SETTLE_FRAMES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_lvl,
    output logic frame_start,
    output logic mod_reset,
    output logic pwr_down,
    output logic pin_force_en,
    output logic pin_force_val,
    output logic valid_gate
);
    localparam int NW = $clog2(PD_FRAMES + 1);
    localparam int SW = $clog2(SETTLE_FRAMES + 1);
    localparam logic [NW-1:0] SYNC_N   = NW'(SYNC_FRAMES);
    localparam logic [NW-1:0] PD_N     = NW'(PD_FRAMES);
    localparam logic [SW-1:0] SETTLE_N = SW'(SETTLE_FRAMES);

    seq_state_t    state_q;
    logic          pulse_q;
    logic [SW-1:0] settle_q;
    logic          tick;
    logic          fall;
    logic          restart;
    logic          freeze;
    logic [NW-1:0] hold_cnt;

    // Release only counts when a held state is active
    always_comb restart = fall && (state_q != ST_RUN);
    always_comb freeze  = (state_q == ST_PDN);

    sqh_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .freeze  (freeze),
        .tick    (tick)
    );

    sqh_hold_counter #(.SAT_FRAMES(PD_FRAMES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .lvl     (sclk_lvl),
        .count   (hold_cnt)
    );

    sqh_fall_detect u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_lvl),
        .fall  (fall)
    );

    // State sequencing; release outranks power-down entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (hold_cnt >= SYNC_N) begin
                        state_q <= ST_SYNC;
                        pulse_q <= 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (fall)                  state_q <= ST_RUN;
                    else if (hold_cnt >= PD_N) state_q <= ST_PDN;
                end
                ST_PDN: begin
                    if (fall) state_q <= ST_RUN;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Settling frames remaining before data-ready may be qualified
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            settle_q <= SETTLE_N;
        else if (tick && state_q == ST_RUN && settle_q != '0)
            settle_q <= settle_q - 1'b1;
    end

    // Output decode
    always_comb begin
        frame_start   = tick;
        mod_reset     = (state_q != ST_RUN);
        pwr_down      = (state_q == ST_PDN);
        pin_force_en  = (state_q != ST_RUN);
        pin_force_val = !pulse_q;
        valid_gate    = (state_q == ST_RUN) && (settle_q == '0);
    end
endmodule

// File: rtl/sclk_hold_sequencer_chk.sv
// Module: property checker for the serial-clock hold sequencer, bound to
// every instance of the top module.
// Assumes: observes top-level ports only.
module sclk_hold_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_lvl,
    input logic frame_start,
    input logic mod_reset,
    input logic pwr_down,
    input logic pin_force_en,
    input logic pin_force_val,
    input logic valid_gate
);
    AST_ENTRY_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset) |-> (pin_force_en && !pin_force_val)); // R2

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_force_en && !pin_force_val) |=> (pin_force_val || !pin_force_en)); // R2

    AST_PD_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> mod_reset); // R4

    AST_FALL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_reset && $fell(sclk_lvl)) |=> (!mod_reset && !pwr_down)); // R5

    AST_GATE_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset |-> !valid_gate); // R6

    AST_NO_FRAME_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !frame_start); // R8
endmodule

bind sclk_hold_sequencer sclk_hold_sequencer_chk u_chk (.*);

// File: tb/sclk_hold_sequencer_test.sv
`timescale 1ns/1ps
module sclk_hold_sequencer_test;
    localparam int FL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_lvl = 1'b0;
    logic frame_start, mod_reset, pwr_down, pin_force_en, pin_force_val, valid_gate;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sclk_hold_sequencer #(.FRAME_LEN(FL), .SYNC_FRAMES(4), .PD_FRAMES(20),
                          .SETTLE_FRAMES(5)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl),
        .frame_start(frame_start), .mod_reset(mod_reset), .pwr_down(pwr_down),
        .pin_force_en(pin_force_en), .pin_force_val(pin_force_val),
        .valid_gate(valid_gate)
    );

    // {frames held high, expected mod_reset, expected pwr_down}
    typedef struct packed { logic [7:0] frames; logic sync; logic pd; } vec_t;
    localparam vec_t VECS [7] = '{
        '{8'd0,  1'b0, 1'b0},
        '{8'd3,  1'b0, 1'b0},
        '{8'd4,  1'b1, 1'b0},
        '{8'd5,  1'b1, 1'b0},
        '{8'd19, 1'b1, 1'b0},
        '{8'd20, 1'b1, 1'b1},
        '{8'd25, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic lvl);
        rst_n = 1'b0;
        sclk_lvl = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_pos(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(1'b0);
        chk("R1 mod_reset", 32'(mod_reset), 0);
        chk("R1 pwr_down", 32'(pwr_down), 0);
        chk("R1 pin_force_en", 32'(pin_force_en), 0);
        chk("R1 valid_gate", 32'(valid_gate), 0);

        // R6 settle after reset with line idle
        wait_pos(79);
        chk("R6 gate before 5th frame", 32'(valid_gate), 0);
        wait_pos(1);
        chk("R6 gate after 5th frame", 32'(valid_gate), 1);

        // Table: R2 R3 R4 R9 thresholds
        for (int i = 0; i < 7; i++) begin
            do_reset(VECS[i].frames != 0);
            wait_pos((VECS[i].frames == 0) ? 3 * FL : VECS[i].frames * FL + 1);
            chk("R2/R3 mod_reset", 32'(mod_reset), 32'(VECS[i].sync));
            chk("R4/R9 pwr_down", 32'(pwr_down), 32'(VECS[i].pd));
        end

        // R2 pin pulse, R5 release, R7 restart, R6 settle after release
        do_reset(1'b1);
        wait_pos(64);
        chk("R2 no override yet", 32'(pin_force_en), 0);
        wait_pos(1);
        chk("R2 override on", 32'(pin_force_en), 1);
        chk("R2 pin low", 32'(pin_force_val), 0);
        wait_pos(1);
        chk("R2 pin high", 32'(pin_force_val), 1);
        wait_pos(3);
        chk("R2 pin still high", 32'(pin_force_val), 1);
        sclk_lvl = 1'b0;
        wait_pos(1);
        chk("R5 mod_reset off", 32'(mod_reset), 0);
        chk("R5 override off", 32'(pin_force_en), 0);
        wait_pos(14);
        chk("R7 no early frame", 32'(frame_start), 0);
        wait_pos(1);
        chk("R7 first frame", 32'(frame_start), 1);
        wait_pos(64);
        chk("R6 gate before settle", 32'(valid_gate), 0);
        wait_pos(1);
        chk("R6 gate after settle", 32'(valid_gate), 1);

        // R3 single low cycle inside frame 4 restarts the count
        do_reset(1'b1);
        wait_pos(50);
        sclk_lvl = 1'b0;
        wait_pos(1);
        sclk_lvl = 1'b1;
        wait_pos(77);
        chk("R3 no sync after 7 frames", 32'(mod_reset), 0);
        wait_pos(1);
        chk("R3 sync after 8 frames", 32'(mod_reset), 1);

        // R8 frozen timing in power-down, then R5 release
        do_reset(1'b1);
        wait_pos(20 * FL + 1);
        chk("R4 pwr_down", 32'(pwr_down), 1);
        chk("R4 mod_reset kept", 32'(mod_reset), 1);
        begin
            int seen = 0;
            for (int k = 0; k < 3 * FL; k++) begin
                if (frame_start) seen++;
                wait_pos(1);
            end
            chk("R8 frame strobes in power-down", 32'(seen), 0);
        end
        sclk_lvl = 1'b0;
        wait_pos(1);
        chk("R5 pwr_down released", 32'(pwr_down), 0);

        // R9 saturation past 20 frames, release still works
        do_reset(1'b1);
        wait_pos(30 * FL);
        chk("R9 pwr_down held", 32'(pwr_down), 1);
        sclk_lvl = 1'b0;
        wait_pos(1);
        chk("R9 released", 32'(mod_reset), 0);

        // R5 release coinciding with power-down threshold
        do_reset(1'b1);
        wait_pos(20 * FL);
        chk("R5 sync before threshold", 32'(mod_reset), 1);
        chk("R5 no pd yet", 32'(pwr_down), 0);
        sclk_lvl = 1'b0;
        wait_pos(1);
        chk("R5 release beats pd", 32'(pwr_down), 0);
        chk("R5 release clears reset", 32'(mod_reset), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule